// File: doc/BRIEF.md
# AGC Gain-State Controller with Lock

This block decides, once per clock, whether a receiver's low-noise amplifier runs at full gain or in its reduced-gain setting. It watches a digitized signal-strength code. When the code reaches an upper threshold, it selects reduced gain at once. It returns to full gain only after the code has stayed under a lower threshold for one millisecond without a break. The gap between the two thresholds is wide enough to cover the drop in the reading that the gain step itself causes, so the loop cannot oscillate.

Two asynchronous control pins shape this behaviour: a power-enable pin and a hold pin. Each passes through its own two-flop synchronizer before any edge is detected. If the hold pin is already high at the moment power is enabled, automatic control is bypassed and full gain is forced. A rising hold pin while powered freezes whichever gain state is current. A falling hold pin while powered resumes automatic control. While power is off, the block keeps full gain, clears its dwell timer and ignores the hold pin.

The thresholds, the code width and the clock frequency that sizes the dwell timer are all parameters.

Top module: `agc_gain_ctrl`

## Requirements
- R1: After synchronous reset, gain_red_o, lock_o and agc_off_o are all 0 (full gain, unlocked, not bypassed).
- R2: In automatic mode at full gain, a code sample >= HI_THR sets gain_red_o to 1 on the next clock edge; a code of HI_THR-1 never sets it.
- R3: In automatic mode at reduced gain, gain_red_o returns to 0 on the edge that takes the DWELL_CYC-th consecutive sample below LO_THR, where DWELL_CYC = CLK_HZ/1000 (one millisecond).
- R4: Any sample >= LO_THR restarts the dwell count, so a low stretch shorter than DWELL_CYC samples leaves gain_red_o at 1.
- R5: At reduced gain, codes in the band LO_THR to HI_THR-1 hold reduced gain for as long as they persist.
- R6: If the synchronized hold input is high when the synchronized power-enable input rises, agc_off_o becomes 1 and gain_red_o stays 0 whatever the code.
- R7: A rising hold input while powered in automatic mode sets lock_o to 1 and freezes gain_red_o at its current value, whether that value is 0 or 1.
- R8: A falling hold input while powered clears lock_o and agc_off_o and restores automatic threshold control.
- R9: While power-enable is low, gain_red_o is 0 and toggles of the hold input have no effect; after power-up with the hold input low, the block is unlocked and automatic.
- R10: Both control inputs pass through two flip-flops. A power-enable change reaches the mode on the third edge, and after power-enable falls, gain_red_o is 0 by the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rssi_code_i | input | CODE_W | Digitized signal-strength code, synchronous to clk_i |
| pwr_en_i | input | 1 | Power-enable (high = powered), asynchronous |
| hold_ctl_i | input | 1 | Hold/disable control, asynchronous |
| gain_red_o | output | 1 | 1 = amplifier in reduced-gain mode |
| lock_o | output | 1 | 1 = gain state frozen by the hold input |
| agc_off_o | output | 1 | 1 = automatic control bypassed at power-up, full gain forced |

## Verification
On every cycle, the assertions check four things. Full gain follows power-down and bypass, and a high code in automatic mode forces reduced gain. A locked state never lets the gain move, and every release from reduced gain in automatic mode follows a sub-threshold sample. The bench's scenarios are needed for the rest: the exact one-millisecond dwell boundary, a dip that restarts one sample short of release, the two-flop latency of the control pins, and the edge-versus-level difference between locking and bypassing at power-up. A behavioural reference model runs alongside and covers every cycle of these scenarios.

// File: rtl/agc_pkg.sv
// Package: shared types for the gain-state controller.
// Assumes: nothing beyond IEEE 1800-2017.
package agc_pkg;

    // Operating mode of the controller
    typedef enum logic [1:0] {
        MODE_DOWN   = 2'd0,  // powered down: full gain, timer cleared
        MODE_AUTO   = 2'd1,  // threshold control active
        MODE_FROZEN = 2'd2,  // gain state held by hold input
        MODE_BYPASS = 2'd3   // hold input high at power-up: full gain forced
    } agc_mode_e;

endpackage

// File: rtl/agc_sync.sv
// Module: multi-stage synchronizer for asynchronous control pins.
// Assumes: inputs are quasi-static levels; STAGES >= 2. Reset clears all stages.
module agc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // first flop: capture raw pins
    always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= async_i;
    end

    // remaining flops: chained by generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (!rst_ni) stage_q[s] <= '0;
            else         stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/agc_mode_fsm.sv
// Module: mode sequencer. Detects power-up and hold-pin edges on synchronized
// inputs and selects down / auto / frozen / bypass.
// Assumes: pwr_s_i and hold_s_i are already synchronous to clk_i.
module agc_mode_fsm
    import agc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      pwr_s_i,
    input  logic      hold_s_i,
    output agc_mode_e mode_o
);

    logic      pwr_prev_q;
    logic      hold_prev_q;
    agc_mode_e mode_q;
    agc_mode_e mode_d;
    logic      pwr_rise;
    logic      hold_rise;
    logic      hold_fall;

    assign pwr_rise  = pwr_s_i & ~pwr_prev_q;
    assign hold_rise = hold_s_i & ~hold_prev_q;
    assign hold_fall = ~hold_s_i & hold_prev_q;

    // next-mode selection from power level and hold-pin edges
    always_comb begin
        mode_d = mode_q;
        if (!pwr_s_i) begin
            mode_d = MODE_DOWN;
        end else if (pwr_rise) begin
            mode_d = hold_s_i ? MODE_BYPASS : MODE_AUTO;
        end else if (hold_rise && mode_q == MODE_AUTO) begin
            mode_d = MODE_FROZEN;
        end else if (hold_fall) begin
            mode_d = MODE_AUTO;
        end
    end

    // state and edge-history registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mode_q      <= MODE_DOWN;
            pwr_prev_q  <= 1'b0;
            hold_prev_q <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            pwr_prev_q  <= pwr_s_i;
            hold_prev_q <= hold_s_i;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/agc_gain_core.sv
// Module: threshold comparison, hysteresis and release dwell timer.
// Assumes: LO_THR < HI_THR; DWELL_CYC >= 2; code is synchronous to clk_i.
module agc_gain_core
    import agc_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int HI_THR    = 200,
    parameter int LO_THR    = 140,
    parameter int DWELL_CYC = 50000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  agc_mode_e         mode_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              gain_red_o
);

    localparam int CNT_W = $clog2(DWELL_CYC + 1);
    localparam logic [CODE_W-1:0] HI_CODE = CODE_W'(HI_THR);
    localparam logic [CODE_W-1:0] LO_CODE = CODE_W'(LO_THR);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DWELL_CYC - 1);

    logic             red_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_hi;
    logic             under_lo;

    assign at_hi    = (code_i >= HI_CODE);
    assign under_lo = (code_i <  LO_CODE);

    // gain state and dwell counter update per mode
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            red_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            unique case (mode_i)
                MODE_AUTO: begin
                    if (!red_q) begin
                        cnt_q <= '0;
                        if (at_hi) red_q <= 1'b1;
                    end else if (!under_lo) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_LAST) begin
                        red_q <= 1'b0;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                MODE_FROZEN: begin
                    cnt_q <= '0;
                end
                default: begin
                    red_q <= 1'b0;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign gain_red_o = red_q;

endmodule

// File: rtl/agc_gain_ctrl.sv
// Module: top of the gain-state controller. Synchronizes control pins,
// sequences modes and drives the reduced-gain flag.
// Assumes: rssi_code_i is synchronous to clk_i; CLK_HZ >= 2000.
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int HI_THR = 200,
    parameter int LO_THR = 140,
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] rssi_code_i,
    input  logic              pwr_en_i,
    input  logic              hold_ctl_i,
    output logic              gain_red_o,
    output logic              lock_o,
    output logic              agc_off_o
);

    localparam int DWELL_CYC = CLK_HZ / 1000;

    logic [1:0] pins_sync;
    agc_mode_e  mode_q;

    agc_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({hold_ctl_i, pwr_en_i}),
        .sync_o  (pins_sync)
    );

    agc_mode_fsm u_mode (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pwr_s_i  (pins_sync[0]),
        .hold_s_i (pins_sync[1]),
        .mode_o   (mode_q)
    );

    agc_gain_core #(
        .CODE_W    (CODE_W),
        .HI_THR    (HI_THR),
        .LO_THR    (LO_THR),
        .DWELL_CYC (DWELL_CYC)
    ) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode_q),
        .code_i     (rssi_code_i),
        .gain_red_o (gain_red_o)
    );

    assign lock_o    = (mode_q == MODE_FROZEN);
    assign agc_off_o = (mode_q == MODE_BYPASS);

endmodule

// File: rtl/agc_gain_ctrl_chk.sv
// Module: property checker bound to agc_gain_ctrl.
// Assumes: mode is the controller's registered mode.
module agc_gain_ctrl_chk
    import agc_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int HI_THR = 200,
    parameter int LO_THR = 140
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CODE_W-1:0] rssi_code_i,
    input logic              gain_red_o,
    input logic              lock_o,
    input logic              agc_off_o,
    input agc_mode_e         mode
);

    assert_down_full_gain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_DOWN) |=> !gain_red_o);

    assert_high_code_reduces_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_AUTO && rssi_code_i >= CODE_W'(HI_THR)) |=> gain_red_o);

    assert_release_needs_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == MODE_AUTO && gain_red_o && rssi_code_i >= CODE_W'(LO_THR)) |=> gain_red_o);

    assert_lock_freezes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_o |=> $stable(gain_red_o));

    assert_bypass_full_gain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        agc_off_o |=> !gain_red_o);

    assert_status_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lock_o && agc_off_o));

endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(
    .CODE_W (CODE_W),
    .HI_THR (HI_THR),
    .LO_THR (LO_THR)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rssi_code_i (rssi_code_i),
    .gain_red_o  (gain_red_o),
    .lock_o      (lock_o),
    .agc_off_o   (agc_off_o),
    .mode        (mode_q)
);

// File: tb/agc_gain_ctrl_tb_top.sv
// Bench: scenario checks plus a behavioural reference model compared each cycle.
module agc_gain_ctrl_tb_top;

    localparam int CODE_W = 8;
    localparam int HI     = 200;
    localparam int LO     = 140;
    localparam int CLK_HZ = 40_000;
    localparam int DW     = CLK_HZ / 1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic              pwr = 1'b0;
    logic              hold = 1'b0;
    logic              gain_red, lock, agc_off;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    agc_gain_ctrl #(.CODE_W(CODE_W), .HI_THR(HI), .LO_THR(LO), .CLK_HZ(CLK_HZ)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rssi_code_i(code), .pwr_en_i(pwr),
        .hold_ctl_i(hold), .gain_red_o(gain_red), .lock_o(lock), .agc_off_o(agc_off)
    );

    // reference model: 0 down, 1 auto, 2 frozen, 3 bypass
    int m_mode = 0;
    int m_cnt = 0;
    bit m_gain = 0;
    bit pwr_h[$] = '{0, 0, 0};
    bit hold_h[$] = '{0, 0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_gain = 0;
            pwr_h = '{0, 0, 0}; hold_h = '{0, 0, 0};
        end else begin
            if (m_mode == 1) begin
                if (!m_gain) begin
                    if (int'(code) >= HI) m_gain = 1;
                end else if (int'(code) >= LO) begin
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                    if (m_cnt == DW) begin m_gain = 0; m_cnt = 0; end
                end
            end else if (m_mode == 2) begin
                m_cnt = 0;
            end else begin
                m_gain = 0; m_cnt = 0;
            end
            if (!pwr_h[1])                          m_mode = 0;
            else if (!pwr_h[2])                     m_mode = hold_h[1] ? 3 : 1;
            else if (hold_h[1] && !hold_h[2] && m_mode == 1) m_mode = 2;
            else if (!hold_h[1] && hold_h[2])       m_mode = 1;
            pwr_h.push_front(pwr);   void'(pwr_h.pop_back());
            hold_h.push_front(hold); void'(hold_h.pop_back());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("model gain", gain_red, m_gain);
            chk("model lock", lock, m_mode == 2);
            chk("model off", agc_off, m_mode == 3);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4ns * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 gain", gain_red, 0); chk("R1 lock", lock, 0); chk("R1 off", agc_off, 0);

        pwr = 1'b1; code = 8'd100; cyc(5);
        code = 8'(HI - 1); cyc(10);
        chk("R2 below HI", gain_red, 0);
        code = 8'(HI); cyc(1);
        chk("R2 at HI", gain_red, 1);
        code = 8'd170; cyc(100);
        chk("R5 band holds", gain_red, 1);
        code = 8'd100; cyc(DW - 5);
        code = 8'(LO); cyc(1);
        code = 8'd100; cyc(DW - 1);
        chk("R4 restart", gain_red, 1);
        cyc(1);
        chk("R3 release at dwell", gain_red, 0);

        code = 8'd220; cyc(2);
        hold = 1'b1; cyc(3);
        chk("R7 lock set", lock, 1);
        code = 8'd50; cyc(100);
        chk("R7 frozen reduced", gain_red, 1);
        hold = 1'b0; cyc(3);
        chk("R8 unlock", lock, 0);
        cyc(DW + 2);
        chk("R8 auto release", gain_red, 0);

        hold = 1'b1; cyc(5);
        code = 8'd255; cyc(20);
        chk("R7 frozen full", gain_red, 0);
        chk("R7 lock held", lock, 1);
        hold = 1'b0; cyc(5);
        chk("R8 auto reduce", gain_red, 1);

        pwr = 1'b0; cyc(3);
        chk("R10 before power-down edge", gain_red, 1);
        cyc(1);
        chk("R10 full gain after drop", gain_red, 0);
        hold = 1'b1; cyc(6); hold = 1'b0; cyc(6);
        chk("R9 down gain", gain_red, 0);
        chk("R9 down lock", lock, 0);
        pwr = 1'b1; cyc(2);
        chk("R10 not yet powered", gain_red, 0);
        cyc(4);
        chk("R9 toggle ignored", lock, 0);
        chk("R9 auto after up", gain_red, 1);

        pwr = 1'b0; cyc(5);
        hold = 1'b1; cyc(5);
        pwr = 1'b1; cyc(8);
        chk("R6 bypass", agc_off, 1);
        chk("R6 full gain", gain_red, 0);
        hold = 1'b0; cyc(5);
        chk("R8 bypass cleared", agc_off, 0);
        chk("R8 auto after bypass", gain_red, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule